// File: doc/BRIEF.md
# Cryptographic bit-permutation execute unit

This unit decodes and executes the six bit-permutation operations of the scalar-cryptography bit-manipulation subset of RISC-V. It takes a 32-bit instruction word and two XLEN-bit source operands (first and second source register values) with a valid strobe. One clock cycle later it presents the result, a valid strobe and an illegal-instruction flag.

The supported operations are halfword packing, low-byte packing, sign-extended 16-bit word packing, per-byte bit reversal, and interleave/de-interleave of the two operand halves. XLEN is a parameter and may be 32 or 64. Operations that only exist at one width are flagged as illegal at the other. The unit claims only these six operations. Every other encoding, including the zero-extend-halfword form that shares the pack encodings, is reported as illegal with a zero result. A pipeline places the unit beside its main ALU and uses the illegal flag to decide which unit owns the instruction.

Top module: `bitperm_xu`

## Requirements
- R1: With opcode 0110011, funct7 (bits 31:25) 0000100, funct3 (bits 14:12) 100 and a non-zero rs2 field (bits 24:20), the result's upper XLEN/2 bits are the low XLEN/2 bits of the second source, and its lower XLEN/2 bits are the low XLEN/2 bits of the first source.
- R2: With opcode 0110011, funct7 0000100 and funct3 111, result bits 15:8 are second-source bits 7:0 and result bits 7:0 are first-source bits 7:0. All other result bits are zero.
- R3: With opcode 0111011, funct7 0000100, funct3 100 and a non-zero rs2 field, a 64-bit unit returns second-source bits 15:0 above first-source bits 15:0, with second-source bit 15 copied into bits 63:32. A 32-bit unit flags this encoding illegal.
- R4: With opcode 0010011, bits 31:20 equal to 0x08F and funct3 001, a 32-bit unit returns result bit 2i equal to first-source bit i and result bit 2i+1 equal to first-source bit i+16, for i in 0..15. A 64-bit unit flags this encoding illegal.
- R5: With opcode 0010011, bits 31:20 equal to 0x08F and funct3 101, a 32-bit unit returns result bit i equal to first-source bit 2i and result bit i+16 equal to first-source bit 2i+1. Applied to an interleaved value, it returns the original. A 64-bit unit flags this encoding illegal.
- R6: With opcode 0010011, bits 31:20 equal to 0x687 and funct3 101, result bit 8k+m equals first-source bit 8k+7-m for every byte k. Byte order is unchanged, and two applications return the original.
- R7: The pack and word-pack encodings of R1 and R3 with a zero rs2 field (zero-extend-halfword) are flagged illegal.
- R8: Every other encoding is flagged illegal. This covers any other opcode, any other funct7/funct3 pair and any other bits 31:20 value. Whenever the illegal flag is high, the result is zero.
- R9: Result, illegal flag and output valid appear on the first rising clock edge after the edge that samples input valid high. Output valid is low after an edge that samples input valid low.
- R10: A synchronous active-high reset clears output valid, the illegal flag and the result, even while input valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | XLEN | First source operand |
| src_b_i | input | XLEN | Second source operand |
| out_valid_o | output | 1 | Registered result is valid |
| illegal_o | output | 1 | Registered instruction was not one of the six operations |
| result_o | output | XLEN | Registered result, zero when illegal |

## Verification
The unit's only internal state is its output register stage. A wrong decode therefore shows at the ports one cycle after the offending instruction, either as a flipped illegal flag or as a non-zero result on an illegal encoding. A wrong bit route shows in the same cycle as a misplaced bit that an arithmetic reference catches. The sweeps cover every rs2 value of the shared pack encodings, every funct3 under the pack funct7, every opcode with the interleave immediate, and single-bit corruptions of both immediates. They also cover all 256 byte patterns for the per-byte reversal and round-trips of the inverse pairs, at both XLEN settings side by side.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

   localparam logic [6:0] OPC_REG  = 7'b0110011;
   localparam logic [6:0] OPC_IMM  = 7'b0010011;
   localparam logic [6:0] OPC_WORD = 7'b0111011;

   localparam logic [6:0]  F7_PACK   = 7'b0000100;
   localparam logic [2:0]  F3_PACK   = 3'b100;
   localparam logic [2:0]  F3_PACKH  = 3'b111;
   localparam logic [2:0]  F3_ZIP    = 3'b001;
   localparam logic [2:0]  F3_UNZIP  = 3'b101;
   localparam logic [11:0] IMM_ZIP   = 12'h08F;
   localparam logic [11:0] IMM_BREV8 = 12'h687;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_PACK  = 3'd1,
      OP_PACKH = 3'd2,
      OP_PACKW = 3'd3,
      OP_BREV8 = 3'd4,
      OP_ZIP   = 3'd5,
      OP_UNZIP = 3'd6
   } perm_op_e;

endpackage

// File: rtl/bitperm_decode.sv
module bitperm_decode
   import bitperm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [31:0] instr_i,
   output perm_op_e    op_o
);
   localparam bit WIDE = (XLEN == 64);

   logic [6:0]  opcode;
   logic [2:0]  funct3;
   logic [6:0]  funct7;
   logic [4:0]  rs2;
   logic [11:0] imm12;
   logic        unused_fields;

   assign opcode        = instr_i[6:0];
   assign funct3        = instr_i[14:12];
   assign funct7        = instr_i[31:25];
   assign rs2           = instr_i[24:20];
   assign imm12         = instr_i[31:20];
   assign unused_fields = ^instr_i[19:15] ^ ^instr_i[11:7];

   always_comb begin
      op_o = OP_NONE;
      unique case (opcode)
         OPC_REG: begin
            if (funct7 == F7_PACK && funct3 == F3_PACKH)
               op_o = OP_PACKH;
            else if (funct7 == F7_PACK && funct3 == F3_PACK && rs2 != 5'd0)
               op_o = OP_PACK;
         end
         OPC_WORD: begin
            if (WIDE && funct7 == F7_PACK && funct3 == F3_PACK && rs2 != 5'd0)
               op_o = OP_PACKW;
         end
         OPC_IMM: begin
            if (!WIDE && imm12 == IMM_ZIP && funct3 == F3_ZIP)
               op_o = OP_ZIP;
            else if (!WIDE && imm12 == IMM_ZIP && funct3 == F3_UNZIP)
               op_o = OP_UNZIP;
            else if (imm12 == IMM_BREV8 && funct3 == F3_UNZIP)
               op_o = OP_BREV8;
         end
         default: op_o = OP_NONE;
      endcase
   end

endmodule

// File: rtl/bitperm_datapath.sv
module bitperm_datapath
   import bitperm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  perm_op_e          op_i,
   input  logic [XLEN-1:0]   src_a_i,
   input  logic [XLEN-1:0]   src_b_i,
   output logic [XLEN-1:0]   result_o
);
   localparam int HALF  = XLEN / 2;
   localparam int BYTES = XLEN / 8;

   logic [XLEN-1:0] pack_w, packh_w, packw_w, brev_w, zip_w, unzip_w;

   assign pack_w  = {src_b_i[HALF-1:0], src_a_i[HALF-1:0]};
   assign packh_w = {{(XLEN-16){1'b0}}, src_b_i[7:0], src_a_i[7:0]};

   for (genvar k = 0; k < BYTES; k++) begin : g_byte
      for (genvar m = 0; m < 8; m++) begin : g_bit
         assign brev_w[8*k+m] = src_a_i[8*k+7-m];
      end
   end

   for (genvar i = 0; i < HALF; i++) begin : g_lace
      assign zip_w[2*i]     = src_a_i[i];
      assign zip_w[2*i+1]   = src_a_i[i+HALF];
      assign unzip_w[i]      = src_a_i[2*i];
      assign unzip_w[i+HALF] = src_a_i[2*i+1];
   end

   if (XLEN == 64) begin : g_word_pack
      assign packw_w = {{(XLEN-32){src_b_i[15]}}, src_b_i[15:0], src_a_i[15:0]};
   end else begin : g_no_word_pack
      assign packw_w = '0;
   end

   always_comb begin
      unique case (op_i)
         OP_PACK:  result_o = pack_w;
         OP_PACKH: result_o = packh_w;
         OP_PACKW: result_o = packw_w;
         OP_BREV8: result_o = brev_w;
         OP_ZIP:   result_o = zip_w;
         OP_UNZIP: result_o = unzip_w;
         default:  result_o = '0;
      endcase
   end

endmodule

// File: rtl/bitperm_xu.sv
module bitperm_xu
   import bitperm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            in_valid_i,
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] src_a_i,
   input  logic [XLEN-1:0] src_b_i,
   output logic            out_valid_o,
   output logic            illegal_o,
   output logic [XLEN-1:0] result_o
);
   localparam int HALF = XLEN / 2;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("bitperm_xu: XLEN must be 32 or 64");
   end

   perm_op_e        dec_op;
   logic            dec_illegal;
   logic [XLEN-1:0] dp_result;
   logic            valid_q, illegal_q;
   logic [XLEN-1:0] result_q;

   bitperm_decode #(.XLEN(XLEN)) u_decode (
      .instr_i (instr_i),
      .op_o    (dec_op)
   );

   bitperm_datapath #(.XLEN(XLEN)) u_datapath (
      .op_i     (dec_op),
      .src_a_i  (src_a_i),
      .src_b_i  (src_b_i),
      .result_o (dp_result)
   );

   assign dec_illegal = (dec_op == OP_NONE);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q   <= 1'b0;
         illegal_q <= 1'b0;
         result_q  <= '0;
      end else begin
         valid_q <= in_valid_i;
         if (in_valid_i) begin
            illegal_q <= dec_illegal;
            result_q  <= dec_illegal ? '0 : dp_result;
         end
      end
   end

   assign out_valid_o = valid_q;
   assign illegal_o   = illegal_q;
   assign result_o    = result_q;

   // R9: output valid follows input valid by one edge
   assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      in_valid_i |=> out_valid_o);
   assert_no_spurious_valid_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      !in_valid_i |=> !out_valid_o);

   // R10: reset clears output valid
   assert_reset_clears_R10: assert property (@(posedge clk_i)
      rst_i |=> (!out_valid_o && !illegal_o && result_o == '0));

   // R8: illegal result is zero
   assert_illegal_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (out_valid_o && illegal_o) |-> (result_o == '0));

   // R1: halves land in place
   assert_pack_halves_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_valid_i && dec_op == OP_PACK) |=>
      (result_o[HALF-1:0] == $past(src_a_i[HALF-1:0]) &&
       result_o[XLEN-1:HALF] == $past(src_b_i[HALF-1:0])));

   // R2: low-byte pack zero-fills above bit 15
   assert_packh_zero_fill_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_valid_i && dec_op == OP_PACKH) |=>
      (result_o[XLEN-1:16] == '0 && result_o[15:8] == $past(src_b_i[7:0])));

   // R4 R5 R6: permutations keep the population count
   assert_perm_popcount_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_valid_i && (dec_op == OP_BREV8 || dec_op == OP_ZIP || dec_op == OP_UNZIP)) |=>
      ($countones(result_o) == $countones($past(src_a_i))));

   if (XLEN == 64) begin : g_chk_word
      // R3: upper word is a copy of bit 31
      assert_packw_sign_R3: assert property (@(posedge clk_i) disable iff (rst_i)
         (in_valid_i && dec_op == OP_PACKW) |=>
         (result_o[XLEN-1:32] == {(XLEN-32){$past(src_b_i[15])}}));
   end

endmodule

// File: tb/bitperm_xu_bench.sv
`timescale 1ns/1ps
module bitperm_xu_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        vld = 1'b0;
   logic [31:0] ins = '0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;

   logic        v64, i64, v32, i32;
   logic [63:0] r64;
   logic [31:0] r32;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bitperm_xu #(.XLEN(64)) u_bitperm_xu (
      .clk_i(clk), .rst_i(rst), .in_valid_i(vld), .instr_i(ins),
      .src_a_i(opa), .src_b_i(opb),
      .out_valid_o(v64), .illegal_o(i64), .result_o(r64));

   bitperm_xu #(.XLEN(32)) u_bitperm_xu_x32 (
      .clk_i(clk), .rst_i(rst), .in_valid_i(vld), .instr_i(ins),
      .src_a_i(opa[31:0]), .src_b_i(opb[31:0]),
      .out_valid_o(v32), .illegal_o(i32), .result_o(r32));

   localparam logic [6:0] RR = 7'b0110011, RI = 7'b0010011, RW = 7'b0111011;

   function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2,
                                         logic [2:0] f3, logic [6:0] opc);
      return {f7, rs2, 5'd3, f3, 5'd9, opc};
   endfunction

   function automatic logic [31:0] enc_i(logic [11:0] imm, logic [2:0] f3, logic [6:0] opc);
      return {imm, 5'd7, f3, 5'd2, opc};
   endfunction

   // returns {illegal, result}
   function automatic logic [64:0] model(int xl, logic [31:0] w, logic [63:0] a, logic [63:0] b);
      logic [63:0] r = '0;
      int kind = 0;
      logic [6:0] opc = w[6:0];
      logic [2:0] f3 = w[14:12];
      logic [6:0] f7 = w[31:25];
      logic [4:0] rs2 = w[24:20];
      logic [11:0] imm = w[31:20];
      if (opc == RR && f7 == 7'd4 && f3 == 3'd7) kind = 2;
      if (opc == RR && f7 == 7'd4 && f3 == 3'd4 && rs2 != 0) kind = 1;
      if (opc == RW && f7 == 7'd4 && f3 == 3'd4 && rs2 != 0 && xl == 64) kind = 3;
      if (opc == RI && imm == 12'h687 && f3 == 3'd5) kind = 4;
      if (opc == RI && imm == 12'h08F && f3 == 3'd1 && xl == 32) kind = 5;
      if (opc == RI && imm == 12'h08F && f3 == 3'd5 && xl == 32) kind = 6;
      case (kind)
         1: for (int i = 0; i < xl / 2; i++) begin r[i] = a[i]; r[i + xl/2] = b[i]; end
         2: for (int i = 0; i < 8; i++) begin r[i] = a[i]; r[i+8] = b[i]; end
         3: begin
            for (int i = 0; i < 16; i++) begin r[i] = a[i]; r[i+16] = b[i]; end
            for (int i = 32; i < 64; i++) r[i] = b[15];
         end
         4: for (int i = 0; i < xl; i++) r[i] = a[(i/8)*8 + 7 - (i%8)];
         5: for (int i = 0; i < 16; i++) begin r[2*i] = a[i]; r[2*i+1] = a[i+16]; end
         6: for (int i = 0; i < 16; i++) begin r[i] = a[2*i]; r[i+16] = a[2*i+1]; end
         default: r = '0;
      endcase
      if (xl == 32) r[63:32] = '0;
      return {kind == 0, r};
   endfunction

   task automatic check(bit ok, string req, string what, logic [64:0] act, logic [64:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(logic [31:0] w, logic [63:0] a, logic [63:0] b, string req,
                         output logic [63:0] res64, output logic [31:0] res32);
      logic [64:0] e64 = model(64, w, a, b);
      logic [64:0] e32 = model(32, w, a, b);
      @(negedge clk);
      ins = w; opa = a; opb = b; vld = 1'b1;
      @(posedge clk);
      #1;
      check(v64 && {i64, r64} == e64, req, "xlen64", {i64, r64}, e64);
      check(v32 && {i32, 32'd0, r32} == e32, req, "xlen32", {i32, 32'd0, r32}, e32);
      res64 = r64; res32 = r32;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] q64, s64, t64;
      logic [31:0] q32, s32, t32;
      logic [31:0] w_zip, w_unz, w_brv;
      w_zip = enc_i(12'h08F, 3'd1, RI);
      w_unz = enc_i(12'h08F, 3'd5, RI);
      w_brv = enc_i(12'h687, 3'd5, RI);

      // R10: reset state with input valid high
      vld = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(!v64 && !i64 && r64 == 0 && !v32 && !i32 && r32 == 0, "R10", "reset",
            {v64, r64}, 65'd0);
      @(negedge clk);
      rst = 1'b0; vld = 1'b0;
      @(posedge clk); #1;
      check(!v64 && !v32, "R9", "idle", {64'd0, v64}, 65'd0);

      // R1 R7: every rs2 value of the shared pack encodings
      for (int s = 0; s < 32; s++) begin
         run_op(enc_r(7'd4, s[4:0], 3'd4, RR), rnd64(), rnd64(), (s == 0) ? "R7" : "R1", q64, q32);
         run_op(enc_r(7'd4, s[4:0], 3'd4, RW), rnd64(), rnd64(), (s == 0) ? "R7" : "R3", q64, q32);
      end

      // R2 R8: every funct3 under the pack funct7, and neighbouring funct7
      for (int f = 0; f < 8; f++) begin
         run_op(enc_r(7'd4, 5'd5, f[2:0], RR), rnd64(), rnd64(), (f == 7) ? "R2" : "R8", q64, q32);
         run_op(enc_r(7'd5, 5'd5, f[2:0], RR), rnd64(), rnd64(), "R8", q64, q32);
         run_op(enc_r(7'd4, 5'd5, f[2:0], RW), rnd64(), rnd64(), (f == 4) ? "R3" : "R8", q64, q32);
      end

      // R8: every opcode with the interleave and reversal immediates
      for (int o = 0; o < 128; o++) begin
         for (int f = 0; f < 8; f++) begin
            run_op(enc_i(12'h08F, f[2:0], o[6:0]), rnd64(), rnd64(), "R8", q64, q32);
         end
         run_op(enc_i(12'h687, 3'd5, o[6:0]), rnd64(), rnd64(), "R8", q64, q32);
      end

      // R8: single-bit corruptions of both immediates
      for (int k = 0; k < 12; k++) begin
         run_op(enc_i(12'h08F ^ (12'd1 << k), 3'd1, RI), rnd64(), rnd64(), "R8", q64, q32);
         run_op(enc_i(12'h08F ^ (12'd1 << k), 3'd5, RI), rnd64(), rnd64(), "R8", q64, q32);
         run_op(enc_i(12'h687 ^ (12'd1 << k), 3'd5, RI), rnd64(), rnd64(), "R8", q64, q32);
      end

      // R1..R6: random operands per operation, including sign bit set and clear
      for (int n = 0; n < 64; n++) begin
         run_op(enc_r(7'd4, 5'd1, 3'd4, RR), rnd64(), rnd64(), "R1", q64, q32);
         run_op(enc_r(7'd4, 5'd2, 3'd7, RR), rnd64(), rnd64(), "R2", q64, q32);
         run_op(enc_r(7'd4, 5'd3, 3'd4, RW), rnd64(), rnd64() ^ (64'(n[0]) << 15), "R3", q64, q32);
         run_op(w_zip, rnd64(), rnd64(), "R4", q64, q32);
         run_op(w_unz, rnd64(), rnd64(), "R5", q64, q32);
         run_op(w_brv, rnd64(), rnd64(), "R6", q64, q32);
      end

      // R6: all byte patterns
      for (int v = 0; v < 256; v++) begin
         run_op(w_brv, {8{v[7:0]}} ^ {56'd0, 8'hA5}, rnd64(), "R6", q64, q32);
      end

      // R5 R6: round trips
      for (int n = 0; n < 32; n++) begin
         t64 = rnd64();
         run_op(w_zip, t64, rnd64(), "R4", q64, q32);
         run_op(w_unz, {32'd0, q32}, rnd64(), "R5", s64, s32);
         check(s32 == t64[31:0], "R5", "unzip(zip)", {33'd0, s32}, {33'd0, t64[31:0]});
         run_op(w_brv, t64, rnd64(), "R6", q64, q32);
         run_op(w_brv, q64, rnd64(), "R6", s64, t32);
         check(s64 == t64, "R6", "brev8 twice", {1'b0, s64}, {1'b0, t64});
         t32 = q32;
         check(t32 == q64[31:0], "R6", "widths agree", {33'd0, t32}, {33'd0, q64[31:0]});
      end

      // R9: bubble drops output valid
      @(negedge clk);
      vld = 1'b0;
      @(posedge clk); #1;
      check(!v64 && !v32, "R9", "bubble", {63'd0, v64, v32}, 65'd0);

      // R10: reset mid-stream
      @(negedge clk);
      vld = 1'b1; rst = 1'b1; ins = w_brv; opa = rnd64();
      @(posedge clk); #1;
      check(!v64 && !v32 && r64 == 0 && r32 == 0, "R10", "mid reset", {v64, r64}, 65'd0);
      @(negedge clk);
      rst = 1'b0; vld = 1'b0;
      @(posedge clk); #1;

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule